// File: doc/BRIEF.md
# Fractional-Accumulator Glide Ramp for a DAC Code Channel

This block serves one DAC channel. It moves the 7-bit code applied to that channel from a starting value to a target value in slow, even steps, instead of jumping there at once. When a trigger arrives with a glide request, a 15-bit accumulator is loaded. Its integer part holds the starting code and its fraction is cleared. On every tick of a private timer the accumulator moves by the absolute code difference. The integer part is driven out as the applied code. Because the step equals the distance to travel, an upward ramp always takes exactly 256 ticks, whatever its size.

The tick period is chosen by a 5-bit step-duration setting that all channels share. The period is 2 × (setting + 1) time units. Each time unit is `UNIT_CYC` cycles of the reference clock. The setting is captured at the trigger, so later writes do not disturb a ramp that is already running. A trigger without a glide request is a plain update: the channel jumps straight to the new code.

A glide request that arrives during a ramp starts a new ramp from the code shown at that moment. A plain update during a ramp cancels it. Clearing the enable freezes the output and ends the ramp for good.

Top module: `glide_ramp_gen`

## Requirements
- R1: After reset, `code_out` is 0 and `gliding` is 0.
- R2: A trigger with `glide_req`=0 while enabled sets `code_out` to `new_code` on the next cycle and clears `gliding`. This holds even when a ramp is in progress.
- R3: A trigger with `glide_req`=1 while enabled, with a start code different from `new_code`, shows the start code on `code_out` on the next cycle and sets `gliding`. The start code is `old_code` when idle. The accumulator starts at start code × 256 and the step is |`new_code` − start code|.
- R4: On each tick the accumulator adds the step when ramping up, or subtracts it when ramping down. `code_out` then shows accumulator bits [14:8]. An upward ramp takes exactly 256 ticks.
- R5: The tick on which bits [14:8] reach or pass the target (at or above it going up, at or below it going down) drives exactly the target onto `code_out` and clears `gliding`. The output then holds.
- R6: A glide trigger whose start code equals `new_code` starts no ramp: `gliding` stays 0 and `code_out` equals `new_code`.
- R7: Ticks come every 2 × (`step_set` + 1) × `UNIT_CYC` clock cycles. The first tick comes one full period after the trigger edge.
- R8: `step_set`, `new_code` and `old_code` are captured at the trigger. Changes to them during a ramp do not alter its pace or its course.
- R9: A glide trigger during a ramp starts the new ramp from the current `code_out`, ignoring `old_code`.
- R10: While `en` is 0, `code_out` holds, `gliding` is 0 and triggers are ignored. After `en` returns to 1 the ramp does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| trig | input | 1 | One-cycle update trigger |
| glide_req | input | 1 | 1: ramp on trigger, 0: direct update |
| old_code | input | 7 | Start code used when no ramp is running |
| new_code | input | 7 | Target code |
| step_set | input | 5 | Step-duration setting, period 2 × (value + 1) units |
| code_out | output | 7 | Applied DAC code (registered) |
| gliding | output | 1 | High while a ramp is in progress |

## Verification
The bench builds the block with `UNIT_CYC`=1 and the default code, fraction and setting widths. A tick period is then just 2 × (setting + 1) clock cycles. That makes complete 256-tick ramps, the longest period (64 cycles) and several mid-ramp interruptions cheap enough to trace tick by tick. Downward ramps are traced against the floor behaviour of the accumulator. A difference of 1 ends after a single tick, while large differences need about 254 ticks.

// File: rtl/glide_pkg.sv
package glide_pkg;
  typedef enum logic {
    RAMP_DOWN = 1'b0,
    RAMP_UP   = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/glide_tick_timer.sv
module glide_tick_timer #(
  parameter int SET_W    = 5,
  parameter int UNIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [SET_W-1:0] step_set,
  output logic             tick
);
  localparam int MAX_CYC = 2 * (2 ** SET_W) * UNIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC);

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (UNIT_CYC == 1) begin : g_unit_one
      // 2*(s+1)-1 = 2s+1
      assign reload_val = CNT_W'({step_set, 1'b1});
    end else begin : g_unit_scaled
      assign reload_val = CNT_W'((32'(step_set) + 32'd1) * 32'(2 * UNIT_CYC) - 32'd1);
    end
  endgenerate

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      per_q <= reload_val;
      cnt_q <= reload_val;
    end else if (run) begin
      cnt_q <= tick ? per_q : cnt_q - 1'b1;
    end
  end

  // R7
  first_tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !tick);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_q);
endmodule

// File: rtl/glide_accum.sv
module glide_accum
  import glide_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              tick,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] end_code,
  output logic [CODE_W-1:0] nxt_code,
  output logic [CODE_W-1:0] target,
  output logic              reached,
  output logic              dir_up
);
  localparam int ACC_W = CODE_W + FRAC_W;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_nxt;
  logic [CODE_W-1:0] step_q;
  logic [CODE_W-1:0] tgt_q;
  ramp_dir_e         dir_q;
  ramp_dir_e         dir_new;

  assign dir_new = (end_code > start_code) ? RAMP_UP : RAMP_DOWN;

  always_comb begin
    if (dir_q == RAMP_UP) acc_nxt = acc_q + ACC_W'(step_q);
    else                  acc_nxt = acc_q - ACC_W'(step_q);
  end

  assign nxt_code = acc_nxt[ACC_W-1 -: CODE_W];
  assign reached  = (dir_q == RAMP_UP) ? (nxt_code >= tgt_q) : (nxt_code <= tgt_q);
  assign target   = tgt_q;
  assign dir_up   = (dir_q == RAMP_UP);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      step_q <= '0;
      tgt_q  <= '0;
      dir_q  <= RAMP_DOWN;
    end else if (load) begin
      acc_q  <= {start_code, {FRAC_W{1'b0}}};
      step_q <= (dir_new == RAMP_UP) ? end_code - start_code : start_code - end_code;
      tgt_q  <= end_code;
      dir_q  <= dir_new;
    end else if (tick) begin
      acc_q  <= acc_nxt;
    end
  end

  // R3
  step_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load && (start_code != end_code) |=> step_q != '0);

  // R4
  acc_up_mono_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !load && (dir_q == RAMP_UP) |=> acc_q > $past(acc_q));
endmodule

// File: rtl/glide_ramp_gen.sv
module glide_ramp_gen #(
  parameter int CODE_W   = 7,
  parameter int FRAC_W   = 8,
  parameter int SET_W    = 5,
  parameter int UNIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              trig,
  input  logic              glide_req,
  input  logic [CODE_W-1:0] old_code,
  input  logic [CODE_W-1:0] new_code,
  input  logic [SET_W-1:0]  step_set,
  output logic [CODE_W-1:0] code_out,
  output logic              gliding
);
  logic [CODE_W-1:0] code_q;
  logic              glide_q;
  logic [CODE_W-1:0] start_code;
  logic              ld_glide;
  logic              tick;
  logic              reached;
  logic              dir_up;
  logic [CODE_W-1:0] nxt_code;
  logic [CODE_W-1:0] target;

  assign start_code = glide_q ? code_q : old_code;
  assign ld_glide   = en && trig && glide_req && (start_code != new_code);

  glide_tick_timer #(
    .SET_W   (SET_W),
    .UNIT_CYC(UNIT_CYC)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (ld_glide),
    .run     (glide_q && en),
    .step_set(step_set),
    .tick    (tick)
  );

  glide_accum #(
    .CODE_W(CODE_W),
    .FRAC_W(FRAC_W)
  ) accum_i (
    .clk       (clk),
    .rst       (rst),
    .load      (ld_glide),
    .tick      (tick),
    .start_code(start_code),
    .end_code  (new_code),
    .nxt_code  (nxt_code),
    .target    (target),
    .reached   (reached),
    .dir_up    (dir_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      glide_q <= 1'b0;
    end else if (!en) begin
      glide_q <= 1'b0;
    end else if (trig) begin
      if (ld_glide) begin
        code_q  <= start_code;
        glide_q <= 1'b1;
      end else begin
        code_q  <= new_code;
        glide_q <= 1'b0;
      end
    end else if (tick) begin
      if (reached) begin
        code_q  <= target;
        glide_q <= 1'b0;
      end else begin
        code_q  <= nxt_code;
      end
    end
  end

  assign code_out = code_q;
  assign gliding  = glide_q;

  // R10
  disable_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(code_q) && !glide_q);

  // R2
  direct_jump_chk: assert property (@(posedge clk) disable iff (rst)
    en && trig && !glide_req |=> (code_q == $past(new_code)) && !glide_q);

  // R6
  equal_no_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    en && trig && glide_req && (start_code == new_code) |=> !glide_q);

  // R5
  ramp_end_chk: assert property (@(posedge clk) disable iff (rst)
    en && !trig && glide_q && tick && reached |=> (code_q == $past(target)) && !glide_q);

  // R4
  ramp_dir_chk: assert property (@(posedge clk) disable iff (rst)
    en && !trig && glide_q && dir_up |=> code_q >= $past(code_q));

  // R9
  restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
    en && trig && glide_req && glide_q && (code_q != new_code) |=> (code_q == $past(code_q)) && glide_q);
endmodule

// File: tb/glide_ramp_gen_tb.sv
module glide_ramp_gen_tb_top;
  localparam int UNIT = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       trig = 1'b0;
  logic       glide_req = 1'b0;
  logic [6:0] old_code = '0;
  logic [6:0] new_code = '0;
  logic [4:0] step_set = '0;
  logic [6:0] code_out;
  logic       gliding;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  glide_ramp_gen #(
    .CODE_W(7), .FRAC_W(8), .SET_W(5), .UNIT_CYC(UNIT)
  ) dut_i (
    .clk(clk), .rst(rst), .en(en), .trig(trig), .glide_req(glide_req),
    .old_code(old_code), .new_code(new_code), .step_set(step_set),
    .code_out(code_out), .gliding(gliding)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(input bit gl, input int oldc, input int nw, input int set);
    glide_req = gl;
    old_code  = 7'(oldc);
    new_code  = 7'(nw);
    step_set  = 5'(set);
    trig      = 1'b1;
    @(negedge clk);
    trig      = 1'b0;
  endtask

  // Trace a ramp tick by tick against the accumulator arithmetic of R3-R5.
  task automatic glide_run(input int old_in, input int start_exp, input int nw,
                           input int set, input bit disturb, input string tag);
    int per = 2 * (set + 1) * UNIT;
    int acc = start_exp * 256;
    int d = (nw > start_exp) ? nw - start_exp : start_exp - nw;
    bit up = nw > start_exp;
    int ticks = 0;
    bit fin = 1'b0;
    fire(1'b1, old_in, nw, set);
    chk(code_out == 7'(start_exp), {tag, " R3 start code"}, int'(code_out), start_exp);
    chk(gliding == 1'b1, {tag, " R3 gliding set"}, int'(gliding), 1);
    if (disturb) begin
      step_set = 5'(31 - set);
      new_code = 7'd5;
      old_code = 7'd77;
    end
    while (!fin && ticks < 300) begin
      repeat (per - 1) @(negedge clk);
      if (ticks == 0)
        chk(code_out == 7'(start_exp), {tag, " R7 no tick before period"}, int'(code_out), start_exp);
      @(negedge clk);
      ticks++;
      acc = up ? acc + d : acc - d;
      if ((up && (acc / 256) >= nw) || (!up && (acc / 256) <= nw)) begin
        fin = 1'b1;
        chk(code_out == 7'(nw), {tag, " R5 final code"}, int'(code_out), nw);
        chk(gliding == 1'b0, {tag, " R5 gliding cleared"}, int'(gliding), 0);
      end else begin
        chk(code_out == 7'(acc / 256), {tag, " R4 ramp code"}, int'(code_out), acc / 256);
        chk(gliding == 1'b1, {tag, " R4 still gliding"}, int'(gliding), 1);
      end
    end
    if (up) chk(ticks == 256, {tag, " R4 tick count"}, ticks, 256);
    repeat (10) @(negedge clk);
    chk(code_out == 7'(nw), {tag, " R5 holds after end"}, int'(code_out), nw);
  endtask

  task automatic t_reset();
    chk(code_out == 7'd0, "R1 reset code", int'(code_out), 0);
    chk(gliding == 1'b0, "R1 reset gliding", int'(gliding), 0);
  endtask

  task automatic t_direct();
    fire(1'b0, 0, 40, 0);
    chk(code_out == 7'd40, "R2 direct update", int'(code_out), 40);
    chk(gliding == 1'b0, "R2 direct gliding", int'(gliding), 0);
  endtask

  task automatic t_up();   glide_run(40, 40, 100, 0, 1'b0, "up");        endtask
  task automatic t_down(); glide_run(100, 100, 10, 1, 1'b0, "down");     endtask
  task automatic t_down_one(); glide_run(10, 10, 9, 31, 1'b0, "R7 long"); endtask

  task automatic t_equal();
    fire(1'b0, 0, 50, 0);
    fire(1'b1, 9, 9, 0);
    chk(code_out == 7'd9, "R6 equal codes output", int'(code_out), 9);
    chk(gliding == 1'b0, "R6 equal codes no ramp", int'(gliding), 0);
    repeat (10) @(negedge clk);
    chk(code_out == 7'd9, "R6 equal codes steady", int'(code_out), 9);
  endtask

  task automatic t_latched(); glide_run(0, 0, 127, 2, 1'b1, "R8 disturbed"); endtask

  task automatic t_retrigger();
    int c;
    fire(1'b1, 127, 0, 0);
    repeat (60) @(negedge clk);
    c = int'(code_out);
    chk(c < 127 && c > 60, "R9 mid ramp code", c, 112);
    glide_run(3, c, 60, 0, 1'b0, "R9 restart");
  endtask

  task automatic t_interrupt();
    fire(1'b1, 0, 100, 0);
    repeat (20) @(negedge clk);
    fire(1'b0, 0, 33, 0);
    chk(code_out == 7'd33, "R2 cancel ramp code", int'(code_out), 33);
    chk(gliding == 1'b0, "R2 cancel ramp gliding", int'(gliding), 0);
    repeat (20) @(negedge clk);
    chk(code_out == 7'd33, "R2 cancel ramp steady", int'(code_out), 33);
  endtask

  task automatic t_disable();
    int c;
    fire(1'b1, 33, 120, 0);
    repeat (30) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    c = int'(code_out);
    chk(gliding == 1'b0, "R10 disable clears gliding", int'(gliding), 0);
    repeat (40) @(negedge clk);
    chk(code_out == 7'(c), "R10 frozen while disabled", int'(code_out), c);
    fire(1'b0, 0, 5, 0);
    chk(code_out == 7'(c), "R10 trigger ignored while disabled", int'(code_out), c);
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk(code_out == 7'(c), "R10 no resume code", int'(code_out), c);
    chk(gliding == 1'b0, "R10 no resume gliding", int'(gliding), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_up();
    t_down();
    t_down_one();
    t_equal();
    t_latched();
    t_retrigger();
    t_interrupt();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule